// File: doc/BRIEF.md
# Dual-Core Writeback Commit Buffer

This block stands between two redundant cores that run the same thread and a shared second-level cache. Each core sends its first-level cache writebacks, an address and a data word, into a queue that only that core writes. A line goes to the shared cache only when both queue heads carry the same line address. That shows both cores finished the write. Exactly one copy then leaves through a valid/ready write port. The data comes from the core-0 queue after error correction. A core that runs ahead keeps queuing until its own queue is full, and its extra entries wait there for the slower core.

Every stored entry carries a SECDED code. A single flipped bit is repaired when the head is read. A double flip raises an uncorrectable flag and blocks the commit. When both heads are valid and their addresses disagree, a mismatch flag is raised and nothing is committed. A recovery request stops all traffic. The buffer then copies the correct core's queue, slot by slot and one slot per cycle, over the faulty core's queue, and finally makes the two sets of pointers equal. An upset input per core flips chosen code bits as an entry is stored, which models a storage fault.

Top module: `wcb_top`

## Requirements
- R1: After reset both queues are empty: both core ready outputs are high, and `l2_valid_o`, `mismatch_o`, `ce_o`, `ue_o` and `rcv_busy_o` are low.
- R2: A line is offered to the shared cache only when both queue heads hold the same address. Exactly one write happens per matched pair, and it carries the address and the corrected core-0 data.
- R3: Entries from a leading core stay queued, with `l2_valid_o` low, until the other core supplies the matching address.
- R4: A core's ready output is low exactly when its queue holds DEPTH (10) entries, and no push is accepted then.
- R5: While `l2_valid_o` is high and `l2_ready_i` is low, the offered address and data stay stable. Both heads are popped only on the handshake.
- R6: When both heads are valid and error-free but their addresses differ, `mismatch_o` is high and no write is offered.
- R7: A single flipped bit in a stored 39-bit code word (bit 0 = overall parity, bits 1..38 = Hamming positions) is corrected. `ce_o` is high while that entry is at a head, and the correct data is written.
- R8: Two flipped bits in a stored code word raise `ue_o` while that entry is at a head, and no write is offered.
- R9: A one-cycle `recover_i` pulse starts a copy lasting DEPTH cycles. During that time `rcv_busy_o` is high, both core ready outputs are low and `l2_valid_o` is low.
- R10: After the copy, the section not named by `good_core_i` (0 = core 0 is correct, 1 = core 1) holds the same entries and pointers as the good section, so a commit of the good core's content follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| c0_valid_i | input | 1 | Core 0 writeback valid |
| c0_ready_o | output | 1 | Core 0 queue can accept |
| c0_addr_i | input | 16 | Core 0 line address |
| c0_data_i | input | 16 | Core 0 line data |
| c0_upset_i | input | 39 | Bits flipped in the core 0 code word as it is stored |
| c1_valid_i | input | 1 | Core 1 writeback valid |
| c1_ready_o | output | 1 | Core 1 queue can accept |
| c1_addr_i | input | 16 | Core 1 line address |
| c1_data_i | input | 16 | Core 1 line data |
| c1_upset_i | input | 39 | Bits flipped in the core 1 code word as it is stored |
| l2_valid_o | output | 1 | Write to shared cache offered |
| l2_ready_i | input | 1 | Shared cache accepts the write |
| l2_addr_o | output | 16 | Committed address |
| l2_data_o | output | 16 | Committed data |
| mismatch_o | output | 1 | Head addresses differ |
| ce_o | output | 1 | Corrected single-bit error at a valid head |
| ue_o | output | 1 | Uncorrectable error at a valid head |
| recover_i | input | 1 | Start the copy-over |
| good_core_i | input | 1 | Section that is correct (sampled with recover_i) |
| rcv_busy_o | output | 1 | Copy-over in progress |

## Verification
The assertions assume that cores raise valid only while their ready output is high. They also assume that `recover_i` is a single-cycle pulse issued while no copy is running and that upset masks flip at most two bits. The stimulus pushes only through a task that waits on ready and issues recovery only from the idle state. It uses upset masks of exactly one or two bits. The sweep runs every queue depth from 1 to 10, with the leading core alternating between the two cores.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int PAY_W  = ADDR_W + DATA_W;
    localparam int PAR_W  = $clog2(PAY_W + $clog2(PAY_W) + 2);
    localparam int CODE_W = PAY_W + PAR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_ent_t;

    typedef struct packed {
        wb_ent_t ent;
        logic    ce;
        logic    ue;
    } dec_res_t;

    typedef enum logic {ST_RUN, ST_COPY} rcv_st_e;

    function automatic logic is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    function automatic logic [CODE_W-1:0] secded_enc(input wb_ent_t e);
        logic [CODE_W-1:0] cw;
        logic [PAY_W-1:0]  pay;
        int                j;
        pay = e;
        cw  = '0;
        j   = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_pow2(i)) begin
                cw[i] = pay[j];
                j++;
            end
        end
        for (int p = 0; p < PAR_W; p++) begin
            logic par;
            par = 1'b0;
            for (int i = 1; i < CODE_W; i++) begin
                if (((i >> p) & 1) == 1) par ^= cw[i];
            end
            cw[1 << p] = par;
        end
        cw[0] = ^cw[CODE_W-1:1];
        return cw;
    endfunction

    function automatic dec_res_t secded_dec(input logic [CODE_W-1:0] cw_in);
        logic [CODE_W-1:0] cw;
        logic [PAR_W-1:0]  syn;
        logic              tot;
        logic [PAY_W-1:0]  pay;
        dec_res_t          r;
        int                j;
        cw  = cw_in;
        syn = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (cw[i]) syn ^= PAR_W'(i);
        end
        tot = ^cw;
        if (tot && (int'(syn) < CODE_W)) cw[syn] = ~cw[syn];
        pay = '0;
        j   = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_pow2(i)) begin
                pay[j] = cw[i];
                j++;
            end
        end
        r.ent = wb_ent_t'(pay);
        r.ce  = tot;
        r.ue  = !tot && (syn != '0);
        return r;
    endfunction

endpackage

// File: rtl/wcb_ecc_dec.sv
module wcb_ecc_dec
    import wcb_pkg::*;
(
    input  logic [CODE_W-1:0] cw_i,
    output dec_res_t          res_o
);
    always_comb res_o = secded_dec(cw_i);
endmodule

// File: rtl/wcb_section.sv
module wcb_section
    import wcb_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              push_i,
    input  wb_ent_t           push_ent_i,
    input  logic [CODE_W-1:0] upset_i,
    input  logic              pop_i,
    output logic [CODE_W-1:0] head_cw_o,
    output logic              empty_o,
    output logic              full_o,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
    output logic [CODE_W-1:0]          rd_cw_o,
    input  logic                       cp_we_i,
    input  logic [$clog2(DEPTH)-1:0]   cp_idx_i,
    input  logic [CODE_W-1:0]          cp_cw_i,
    input  logic                       ld_i,
    input  logic [$clog2(DEPTH)-1:0]   ld_head_i,
    input  logic [$clog2(DEPTH)-1:0]   ld_tail_i,
    input  logic [$clog2(DEPTH+1)-1:0] ld_cnt_i,
    output logic [$clog2(DEPTH)-1:0]   head_o,
    output logic [$clog2(DEPTH)-1:0]   tail_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CODE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (push_i) mem[tail_q] <= secded_enc(push_ent_i) ^ upset_i;
        if (cp_we_i) mem[cp_idx_i] <= cp_cw_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (ld_i) begin
            head_q <= ld_head_i;
            tail_q <= ld_tail_i;
            cnt_q  <= ld_cnt_i;
        end else begin
            if (push_i) tail_q <= nxt(tail_q);
            if (pop_i)  head_q <= nxt(head_q);
            case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_cw_o = mem[head_q];
    assign rd_cw_o   = mem[rd_idx_i];
    assign empty_o   = (cnt_q == '0);
    assign full_o    = (cnt_q == CNT_W'(DEPTH));
    assign head_o    = head_q;
    assign tail_o    = tail_q;
    assign cnt_o     = cnt_q;

    // R4
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        push_i |-> (!full_o || pop_i));
    // R5
    no_underflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pop_i |-> !empty_o);
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
    import wcb_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     v0_i,
    input  logic     v1_i,
    input  dec_res_t d0_i,
    input  dec_res_t d1_i,
    input  logic     l2_ready_i,
    input  logic     recover_i,
    input  logic     good_core_i,
    output logic     run_o,
    output logic     l2_valid_o,
    output wb_ent_t  l2_ent_o,
    output logic     pop_o,
    output logic     mismatch_o,
    output logic     ce_o,
    output logic     ue_o,
    output logic     busy_o,
    output logic [$clog2(DEPTH)-1:0] cp_idx_o,
    output logic     good_o,
    output logic     cp_we_o,
    output logic     ld_o
);
    localparam int PTR_W = $clog2(DEPTH);

    rcv_st_e          st_q;
    logic [PTR_W-1:0] idx_q;
    logic             good_q;
    logic             both, err_ue, same;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_RUN;
            idx_q  <= '0;
            good_q <= 1'b0;
        end else if (st_q == ST_RUN) begin
            if (recover_i) begin
                st_q   <= ST_COPY;
                idx_q  <= '0;
                good_q <= good_core_i;
            end
        end else begin
            if (idx_q == PTR_W'(DEPTH - 1)) st_q <= ST_RUN;
            else idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        both   = v0_i && v1_i;
        err_ue = (v0_i && d0_i.ue) || (v1_i && d1_i.ue);
        same   = (d0_i.ent.addr == d1_i.ent.addr);
    end

    assign run_o      = (st_q == ST_RUN);
    assign busy_o     = (st_q == ST_COPY);
    assign l2_valid_o = run_o && both && !err_ue && same;
    assign l2_ent_o   = d0_i.ent;
    assign pop_o      = l2_valid_o && l2_ready_i;
    assign mismatch_o = both && !err_ue && !same;
    assign ue_o       = err_ue;
    assign ce_o       = (v0_i && d0_i.ce) || (v1_i && d1_i.ce);
    assign cp_idx_o   = idx_q;
    assign good_o     = good_q;
    assign cp_we_o    = busy_o;
    assign ld_o       = busy_o && (idx_q == PTR_W'(DEPTH - 1));

    // R8
    ue_blocks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ue_o |-> !l2_valid_o);
    // R9
    copy_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && idx_q != PTR_W'(DEPTH - 1)) |=> busy_o);
endmodule

// File: rtl/wcb_top.sv
module wcb_top
    import wcb_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              c0_valid_i,
    output logic              c0_ready_o,
    input  logic [ADDR_W-1:0] c0_addr_i,
    input  logic [DATA_W-1:0] c0_data_i,
    input  logic [CODE_W-1:0] c0_upset_i,
    input  logic              c1_valid_i,
    output logic              c1_ready_o,
    input  logic [ADDR_W-1:0] c1_addr_i,
    input  logic [DATA_W-1:0] c1_data_i,
    input  logic [CODE_W-1:0] c1_upset_i,
    output logic              l2_valid_o,
    input  logic              l2_ready_i,
    output logic [ADDR_W-1:0] l2_addr_o,
    output logic [DATA_W-1:0] l2_data_o,
    output logic              mismatch_o,
    output logic              ce_o,
    output logic              ue_o,
    input  logic              recover_i,
    input  logic              good_core_i,
    output logic              rcv_busy_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NSEC  = 2;

    logic              vld   [NSEC];
    wb_ent_t           ent   [NSEC];
    logic [CODE_W-1:0] ups   [NSEC];
    logic              push  [NSEC];
    logic              rdy   [NSEC];
    logic              empty [NSEC];
    logic              full  [NSEC];
    logic [CODE_W-1:0] hcw   [NSEC];
    logic [CODE_W-1:0] rcw   [NSEC];
    dec_res_t          dec   [NSEC];
    logic [PTR_W-1:0]  hd    [NSEC];
    logic [PTR_W-1:0]  tl    [NSEC];
    logic [CNT_W-1:0]  cn    [NSEC];

    logic             run, pop, cp_we, ld, good;
    logic [PTR_W-1:0] cp_idx;
    wb_ent_t          l2_ent;

    assign vld[0] = c0_valid_i;
    assign vld[1] = c1_valid_i;
    assign ent[0] = '{addr: c0_addr_i, data: c0_data_i};
    assign ent[1] = '{addr: c1_addr_i, data: c1_data_i};
    assign ups[0] = c0_upset_i;
    assign ups[1] = c1_upset_i;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        localparam int OTHER = NSEC - 1 - s;
        logic victim;
        assign victim  = (good != 1'(s));
        assign rdy[s]  = run && !full[s];
        assign push[s] = vld[s] && rdy[s];

        wcb_section #(.DEPTH(DEPTH)) sec_i (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .push_i     (push[s]),
            .push_ent_i (ent[s]),
            .upset_i    (ups[s]),
            .pop_i      (pop),
            .head_cw_o  (hcw[s]),
            .empty_o    (empty[s]),
            .full_o     (full[s]),
            .rd_idx_i   (cp_idx),
            .rd_cw_o    (rcw[s]),
            .cp_we_i    (cp_we && victim),
            .cp_idx_i   (cp_idx),
            .cp_cw_i    (rcw[OTHER]),
            .ld_i       (ld && victim),
            .ld_head_i  (hd[OTHER]),
            .ld_tail_i  (tl[OTHER]),
            .ld_cnt_i   (cn[OTHER]),
            .head_o     (hd[s]),
            .tail_o     (tl[s]),
            .cnt_o      (cn[s])
        );

        wcb_ecc_dec dec_i (
            .cw_i  (hcw[s]),
            .res_o (dec[s])
        );
    end

    wcb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .v0_i        (!empty[0]),
        .v1_i        (!empty[1]),
        .d0_i        (dec[0]),
        .d1_i        (dec[1]),
        .l2_ready_i  (l2_ready_i),
        .recover_i   (recover_i),
        .good_core_i (good_core_i),
        .run_o       (run),
        .l2_valid_o  (l2_valid_o),
        .l2_ent_o    (l2_ent),
        .pop_o       (pop),
        .mismatch_o  (mismatch_o),
        .ce_o        (ce_o),
        .ue_o        (ue_o),
        .busy_o      (rcv_busy_o),
        .cp_idx_o    (cp_idx),
        .good_o      (good),
        .cp_we_o     (cp_we),
        .ld_o        (ld)
    );

    assign c0_ready_o = rdy[0];
    assign c1_ready_o = rdy[1];
    assign l2_addr_o  = l2_ent.addr;
    assign l2_data_o  = l2_ent.data;

    // R5
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (l2_valid_o && !l2_ready_i && !recover_i) |=>
            (l2_valid_o && $stable(l2_addr_o) && $stable(l2_data_o)));
    // R9
    halt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rcv_busy_o |-> (!c0_ready_o && !c1_ready_o && !l2_valid_o));
    // R10
    ptr_equal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rcv_busy_o) |-> (hd[0] == hd[1] && tl[0] == tl[1] && cn[0] == cn[1]));
    // R2
    commit_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        l2_valid_o |-> (!empty[0] && !empty[1] && !mismatch_o));
endmodule

// File: tb/wcb_top_tb_top.sv
module wcb_top_tb_top;
    import wcb_pkg::*;

    localparam int DEPTH = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c0_valid = 0, c1_valid = 0, l2_ready = 0, recover = 0, good_core = 0;
    logic [ADDR_W-1:0] c0_addr = '0, c1_addr = '0;
    logic [DATA_W-1:0] c0_data = '0, c1_data = '0;
    logic [CODE_W-1:0] c0_up = '0, c1_up = '0;
    logic c0_ready, c1_ready, l2_valid, mismatch, ce, ue, busy;
    logic [ADDR_W-1:0] l2_addr;
    logic [DATA_W-1:0] l2_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wcb_top #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .c0_valid_i(c0_valid), .c0_ready_o(c0_ready), .c0_addr_i(c0_addr),
        .c0_data_i(c0_data), .c0_upset_i(c0_up),
        .c1_valid_i(c1_valid), .c1_ready_o(c1_ready), .c1_addr_i(c1_addr),
        .c1_data_i(c1_data), .c1_upset_i(c1_up),
        .l2_valid_o(l2_valid), .l2_ready_i(l2_ready), .l2_addr_o(l2_addr),
        .l2_data_o(l2_data), .mismatch_o(mismatch), .ce_o(ce), .ue_o(ue),
        .recover_i(recover), .good_core_i(good_core), .rcv_busy_o(busy)
    );

    function automatic logic [15:0] dat_of(input logic [15:0] a);
        return (a * 16'd37) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int c, input logic [15:0] a, input logic [15:0] d,
                        input logic [CODE_W-1:0] up);
        @(negedge clk);
        if (c == 0) begin c0_valid = 1; c0_addr = a; c0_data = d; c0_up = up; end
        else        begin c1_valid = 1; c1_addr = a; c1_data = d; c1_up = up; end
        @(negedge clk);
        c0_valid = 0; c1_valid = 0; c0_up = '0; c1_up = '0;
    endtask

    task automatic drain(input int n, input logic [15:0] base, input logic [15:0] dbase);
        l2_ready = 1;
        for (int k = 0; k < n; k++) begin
            chk(l2_valid == 1, "R2 valid", l2_valid, 1);
            chk(l2_addr == base + 16'(k), "R2 addr", l2_addr, base + 16'(k));
            chk(l2_data == dat_of(dbase + 16'(k)), "R2 data", l2_data, dat_of(dbase + 16'(k)));
            @(negedge clk);
        end
        l2_ready = 0;
        chk(l2_valid == 0, "R2 single copy", l2_valid, 0);
    endtask

    task automatic do_recover(input logic g);
        recover = 1; good_core = g;
        @(negedge clk);
        recover = 0;
        for (int k = 0; k < DEPTH; k++) begin
            chk(busy == 1, "R9 busy", busy, 1);
            chk(!c0_ready && !c1_ready && !l2_valid, "R9 halt",
                {c0_ready, c1_ready, l2_valid}, 0);
            @(negedge clk);
        end
        chk(busy == 0, "R9 end", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(c0_ready && c1_ready, "R1 ready", {c0_ready, c1_ready}, 3);
        chk(!l2_valid && !mismatch && !ce && !ue && !busy, "R1 flags",
            {l2_valid, mismatch, ce, ue, busy}, 0);

        // R3 R4 R2: sweep every depth, alternating the leading core
        for (int n = 1; n <= DEPTH; n++) begin
            int lead = n % 2;
            logic [15:0] base = 16'(n * 256);
            for (int k = 0; k < n; k++) push(lead, base + 16'(k), dat_of(base + 16'(k)), '0);
            chk(l2_valid == 0, "R3 leader waits", l2_valid, 0);
            if (lead == 0) chk(c0_ready == (n < DEPTH), "R4 ready", c0_ready, n < DEPTH);
            else           chk(c1_ready == (n < DEPTH), "R4 ready", c1_ready, n < DEPTH);
            for (int k = 0; k < n; k++) push(1 - lead, base + 16'(k), dat_of(base + 16'(k)), '0);
            drain(n, base, base);
            chk(c0_ready && c1_ready, "R2 empty after drain", {c0_ready, c1_ready}, 3);
        end

        // R5: held offer stays stable
        push(0, 16'h0077, dat_of(16'h0077), '0);
        push(1, 16'h0077, dat_of(16'h0077), '0);
        repeat (3) @(negedge clk);
        chk(l2_valid && l2_addr == 16'h0077 && l2_data == dat_of(16'h0077),
            "R5 hold", l2_addr, 16'h0077);
        drain(1, 16'h0077, 16'h0077);

        // R6 then R9/R10 with core 0 good
        push(0, 16'h0A00, dat_of(16'h0A00), '0);
        push(1, 16'h0B00, dat_of(16'h0B00), '0);
        chk(mismatch == 1, "R6 flag", mismatch, 1);
        chk(l2_valid == 0, "R6 no commit", l2_valid, 0);
        do_recover(1'b0);
        chk(mismatch == 0, "R10 mismatch cleared", mismatch, 0);
        drain(1, 16'h0A00, 16'h0A00);

        // R7: single upset, every code bit position
        for (int b = 0; b < CODE_W; b++) begin
            logic [15:0] a = 16'(16'h2000 + b);
            push(b % 2, a, dat_of(a), CODE_W'(1) << b);
            push(1 - (b % 2), a, dat_of(a), '0);
            chk(ce == 1, "R7 ce", ce, 1);
            chk(ue == 0, "R7 no ue", ue, 0);
            drain(1, a, a);
        end

        // R8 then R10 with core 1 good: core 0 data replaced
        push(0, 16'h0C00, 16'hDEAD, (CODE_W'(1) << 3) | (CODE_W'(1) << 20));
        push(1, 16'h0C00, dat_of(16'h0C00), '0);
        chk(ue == 1, "R8 ue", ue, 1);
        chk(l2_valid == 0, "R8 no commit", l2_valid, 0);
        do_recover(1'b1);
        chk(ue == 0, "R10 ue cleared", ue, 0);
        drain(1, 16'h0C00, 16'h0C00);

        // R10: copy of a partly filled good section with a lagging victim
        for (int k = 0; k < 3; k++) push(1, 16'h0D00 + 16'(k), dat_of(16'h0D00 + 16'(k)), '0);
        do_recover(1'b1);
        drain(3, 16'h0D00, 16'h0D00);
        chk(c0_ready && c1_ready, "R10 both empty", {c0_ready, c1_ready}, 3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule